// File: doc/BRIEF.md
# Interrupt Line Port Selector

This block steers GPIO pin levels onto sixteen external-interrupt lines. Nine GPIO ports with sixteen pins each give 144 input levels. Each interrupt line with number p can be driven only by pin p of one port. A 4-bit field chosen by software picks that port. The selected level reaches the line combinationally, so whatever sits downstream (edge detection, masking, pending state) sees the pin directly and adds no latency.

Software reaches the block through a plain 32-bit read/write slave port that decodes a 0x400-byte window. The window holds these registers:

- Four selection registers, each packing four line fields into its low half.
- A compensation-control register that stores every bit written to it.
- A memory-remap register and a peripheral-mode register. Both are kept for software compatibility: they read back their stored value, and writes to them are discarded.

Top module: `irqsel_top`

## Requirements
- R1: After reset every register reads 0x00000000, and every line k follows input k (port 0, pin k).
- R2: Line p is steered by the field at bits [(p mod 4)*4+3 : (p mod 4)*4] of the selection register at byte offset 0x08 + 4*(p/4). Line p equals input (field*16 + p), where the input index is port*16 + pin.
- R3: A field value of 9 to 15 selects no port, and the line it steers is held at 0.
- R4: A write to a selection register stores only data bits 15:0, and bits 31:16 of that register always read as zero.
- R5: Writes to the remap register (offset 0x00) and the peripheral-mode register (offset 0x04) are discarded, and both keep reading 0x00000000.
- R6: The compensation-control register (offset 0x20) stores all 32 written bits and reads them back unchanged.
- R7: A read from any other offset in the window, or from an offset that is not word aligned, returns 0, and a write there changes no register.
- R8: A write is accepted on the rising clock edge where busWrite is high, and the new routing appears on the lines only after that edge.
- R9: A pin on a port that its line's field does not select has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe, sampled on the rising clock edge |
| busAddr | input | 10 | Byte offset within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pinLevels | input | 144 | GPIO levels, index port*16 + pin |
| lineOut | output | 16 | Interrupt line levels |

## Verification
The hardest behaviour to reach from the ports is isolation: a line must ignore every port except the one its field selects. The bench points a line at one port and then toggles the same pin on each of the other eight ports in turn, checking that the line stays still, before toggling the selected port and checking that the line follows. The other hard case is the timing of a write. The bench raises the write at a falling edge and samples a line both before and after the next rising edge, to show that the new routing takes effect at that edge and not earlier.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int PIN_COUNT   = 16;
  localparam int FIELD_W     = 4;
  localparam int FIELDS_PER  = 4;
  localparam int SEL_REGS    = PIN_COUNT / FIELDS_PER;
  localparam int SEL_KEEP_W  = FIELDS_PER * FIELD_W;
  localparam int DATA_W      = 32;

  typedef struct packed {
    logic                wrCmp;
    logic [SEL_REGS-1:0] wrSel;
    logic                rdRemap;
    logic                rdPmode;
    logic                rdCmp;
    logic [SEL_REGS-1:0] rdSel;
  } regStrobe_t;
endpackage

// File: rtl/irqsel_ctrl.sv
module irqsel_ctrl
  import irqsel_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int OFS_REMAP = 'h00,
  parameter int OFS_PMODE = 'h04,
  parameter int OFS_SEL   = 'h08,
  parameter int OFS_CMP   = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        stb
);
  logic aligned;
  logic hitRemap, hitPmode, hitCmp;
  logic [SEL_REGS-1:0] hitSel;

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign hitRemap = aligned && (busAddr == ADDR_W'(OFS_REMAP));
  assign hitPmode = aligned && (busAddr == ADDR_W'(OFS_PMODE));
  assign hitCmp   = aligned && (busAddr == ADDR_W'(OFS_CMP));

  for (genvar i = 0; i < SEL_REGS; i++) begin : g_selDecode
    assign hitSel[i] = aligned && (busAddr == ADDR_W'(OFS_SEL + 4 * i));
  end

  always_comb begin
    stb         = '0;
    stb.rdRemap = hitRemap;
    stb.rdPmode = hitPmode;
    stb.rdCmp   = hitCmp;
    stb.rdSel   = hitSel;
    stb.wrCmp   = busWrite && hitCmp;
    stb.wrSel   = busWrite ? hitSel : '0;
  end

  AST_ONE_READ_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rdRemap, stb.rdPmode, stb.rdCmp, stb.rdSel})) // R7
    else $error("more than one register decoded");

  AST_WRITE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !busWrite |-> (stb.wrSel == '0 && !stb.wrCmp)) // R8
    else $error("write strobe without bus write");
endmodule

// File: rtl/irqsel_dp.sv
module irqsel_dp
  import irqsel_pkg::*;
#(
  parameter int PORT_COUNT = 9
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  regStrobe_t                        stb,
  input  logic [DATA_W-1:0]                 busWdata,
  output logic [DATA_W-1:0]                 busRdata,
  input  logic [PORT_COUNT*PIN_COUNT-1:0]   pinLevels,
  output logic [PIN_COUNT-1:0]              lineOut
);
  localparam int SPAN = 1 << FIELD_W;

  logic [SEL_REGS-1:0][SEL_KEEP_W-1:0] selRegs;
  logic [DATA_W-1:0] cmpReg;
  logic [DATA_W-1:0] remapReg;
  logic [DATA_W-1:0] pmodeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remapReg <= '0;
      pmodeReg <= '0;
    end else begin
      remapReg <= remapReg;
      pmodeReg <= pmodeReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmpReg <= '0;
    else if (stb.wrCmp) cmpReg <= busWdata;
  end

  for (genvar r = 0; r < SEL_REGS; r++) begin : g_selReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) selRegs[r] <= '0;
      else if (stb.wrSel[r]) selRegs[r] <= busWdata[SEL_KEEP_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (stb.rdRemap) busRdata = remapReg;
    if (stb.rdPmode) busRdata = pmodeReg;
    if (stb.rdCmp)   busRdata = cmpReg;
    for (int r = 0; r < SEL_REGS; r++) begin
      if (stb.rdSel[r]) busRdata = {{(DATA_W-SEL_KEEP_W){1'b0}}, selRegs[r]};
    end
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_line
    localparam int REG_IDX = p / FIELDS_PER;
    localparam int BIT_LO  = (p % FIELDS_PER) * FIELD_W;
    logic [FIELD_W-1:0] field;
    logic [SPAN-1:0]    portBits;

    assign field = selRegs[REG_IDX][BIT_LO +: FIELD_W];

    for (genvar k = 0; k < SPAN; k++) begin : g_port
      if (k < PORT_COUNT) begin : g_real
        assign portBits[k] = pinLevels[k*PIN_COUNT + p];
      end else begin : g_none
        assign portBits[k] = 1'b0;
      end
    end

    assign lineOut[p] = portBits[field];

    AST_NO_PORT_LOW: assert property (@(posedge clk) disable iff (!rstN)
      (int'(field) >= PORT_COUNT) |-> !lineOut[p]) // R3
      else $error("unselected line %0d not low", p);
  end

  AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel != '0) |-> (busRdata[DATA_W-1:SEL_KEEP_W] == '0)) // R4
    else $error("selection register upper bits nonzero");

  AST_CMP_STORES: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCmp |=> (cmpReg == $past(busWdata))) // R6
    else $error("compensation register lost write data");

  AST_LOCKED_REGS: assert property (@(posedge clk) disable iff (!rstN)
    (remapReg == '0) && (pmodeReg == '0)) // R5
    else $error("locked register changed");

  AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSel == '0 && !stb.wrCmp) |=> ($stable(selRegs) && $stable(cmpReg))) // R7
    else $error("register changed without a decoded write");
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
  import irqsel_pkg::*;
#(
  parameter int PORT_COUNT = 9,
  parameter int ADDR_W     = 10
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busWrite,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [DATA_W-1:0]               busWdata,
  output logic [DATA_W-1:0]               busRdata,
  input  logic [PORT_COUNT*PIN_COUNT-1:0] pinLevels,
  output logic [PIN_COUNT-1:0]            lineOut
);
  regStrobe_t stb;

  irqsel_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .stb      (stb)
  );

  irqsel_dp #(.PORT_COUNT(PORT_COUNT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .pinLevels (pinLevels),
    .lineOut   (lineOut)
  );
endmodule

// File: tb/tb_irqsel_top.sv
module tb_irqsel_top;
  localparam int CLK_PERIOD = 10;
  localparam int PORTS = 9;
  localparam int PINS  = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWrite = 1'b0;
  logic [9:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [PORTS*PINS-1:0] pinLevels = '0;
  logic [PINS-1:0] lineOut;

  int checks = 0;
  int fails  = 0;
  logic [15:0] selModel [4];

  irqsel_top dut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinLevels(pinLevels),
    .lineOut(lineOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(posedge clk); #1;
    busWrite = 1'b0;
  endtask

  task automatic busRd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrite = 1'b0;
    #1 d = busRdata;
  endtask

  function automatic logic [15:0] expLines();
    logic [15:0] v;
    for (int p = 0; p < PINS; p++) begin
      int f;
      f = int'(selModel[p/4][(p%4)*4 +: 4]);
      v[p] = (f < PORTS) ? pinLevels[f*PINS + p] : 1'b0;
    end
    return v;
  endfunction

  task automatic testReset();
    logic [31:0] d;
    for (int a = 0; a < 'h24; a += 4) begin
      busRd(10'(a), d);
      check("R1 reset read", d, 32'h0);
    end
    pinLevels = '0;
    pinLevels[PINS-1:0] = 16'hA5C3;
    #1 check("R1 port0 default", {16'h0, lineOut}, 32'h0000A5C3);
  endtask

  task automatic testRouting();
    logic [31:0] d;
    selModel[0] = 16'h8312; selModel[1] = 16'h4567;
    selModel[2] = 16'h0813; selModel[3] = 16'h2607;
    for (int r = 0; r < 4; r++) busWr(10'(8 + 4*r), {16'hFFFF, selModel[r]});
    for (int r = 0; r < 4; r++) begin
      busRd(10'(8 + 4*r), d);
      check("R4 sel readback", d, {16'h0, selModel[r]});
    end
    for (int pat = 0; pat < 6; pat++) begin
      @(negedge clk);
      for (int k = 0; k < PORTS*PINS; k++)
        pinLevels[k] = ((k * (pat + 3) + pat) % 5) < 2;
      #1 check("R2 routing pattern", {16'h0, lineOut}, {16'h0, expLines()});
    end
  endtask

  task automatic testNoPort();
    selModel[1] = 16'hF9AB;
    busWr(10'h0C, {16'h0, selModel[1]});
    @(negedge clk);
    pinLevels = '1;
    #1 check("R3 field>=9 low", {28'h0, lineOut[7:4]}, 32'h0);
    check("R3 others high", {16'h0, lineOut}, {16'h0, expLines()});
  endtask

  task automatic testIsolation();
    selModel[1] = 16'h0030;
    busWr(10'h0C, {16'h0, selModel[1]});
    @(negedge clk);
    pinLevels = '0;
    for (int k = 0; k < PORTS; k++) begin
      if (k != 3) begin
        @(negedge clk);
        pinLevels[k*PINS + 5] = 1'b1;
        #1 check("R9 other port ignored", {31'h0, lineOut[5]}, 32'h0);
        pinLevels[k*PINS + 5] = 1'b0;
      end
    end
    @(negedge clk);
    pinLevels[3*PINS + 5] = 1'b1;
    #1 check("R9 selected port follows", {31'h0, lineOut[5]}, 32'h1);
  endtask

  task automatic testLocked();
    logic [31:0] d;
    busWr(10'h000, 32'hDEADBEEF);
    busWr(10'h004, 32'h12345678);
    busRd(10'h000, d); check("R5 remap ignored", d, 32'h0);
    busRd(10'h004, d); check("R5 pmode ignored", d, 32'h0);
  endtask

  task automatic testCmp();
    logic [31:0] d;
    busWr(10'h020, 32'hCAFE0101);
    busRd(10'h020, d); check("R6 cmp full word", d, 32'hCAFE0101);
    busWr(10'h020, 32'h80000000);
    busRd(10'h020, d); check("R6 cmp top bit", d, 32'h80000000);
  endtask

  task automatic testUndecoded();
    logic [31:0] d;
    busWr(10'h018, 32'hFFFFFFFF);
    busWr(10'h3FC, 32'hFFFFFFFF);
    busWr(10'h009, 32'hFFFFFFFF);
    busWr(10'h022, 32'hFFFFFFFF);
    busRd(10'h018, d); check("R7 hole read", d, 32'h0);
    busRd(10'h1C0, d); check("R7 far read", d, 32'h0);
    busRd(10'h021, d); check("R7 unaligned read", d, 32'h0);
    for (int r = 0; r < 4; r++) begin
      busRd(10'(8 + 4*r), d);
      check("R7 sel untouched", d, {16'h0, selModel[r]});
    end
    busRd(10'h020, d); check("R7 cmp untouched", d, 32'h80000000);
  endtask

  task automatic testTiming();
    selModel[0] = 16'h0000;
    busWr(10'h008, 32'h0);
    @(negedge clk);
    pinLevels = '0;
    pinLevels[2*PINS + 0] = 1'b1;
    busAddr = 10'h008; busWdata = 32'h0002; busWrite = 1'b1;
    #1 check("R8 before edge old", {31'h0, lineOut[0]}, 32'h0);
    @(posedge clk); #1;
    busWrite = 1'b0;
    selModel[0] = 16'h0002;
    check("R8 after edge new", {31'h0, lineOut[0]}, 32'h1);
  endtask

  initial begin
    for (int r = 0; r < 4; r++) selModel[r] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testRouting();
    testNoPort();
    testIsolation();
    testLocked();
    testCmp();
    testUndecoded();
    testTiming();
    summary();
  end
endmodule